// File: doc/BRIEF.md
# Register-Pair Word ALU

This block performs 16-bit arithmetic on a pair of 8-bit registers that are handled as one word: the high byte is Y and the low byte is A, joined as YA. A second 16-bit word comes from memory, already assembled by the surrounding datapath. One operation is issued per cycle with a valid strobe. The operation is an add, a subtract or a load. The block returns the new YA word and five status flags: N, V, H, Z and C. Each flag has its own write enable, so the register file knows which flags to commit.

Results and flags are registered. They appear one clock after the strobe, together with a result-valid output. An add or subtract writes all five flags. A load writes only N and Z, and the block holds the other three flag outputs at their previous values. The byte width, the bit position that feeds the half-carry flag, and the adder structure (one wide adder or two chained segments split at the half-carry boundary) are parameters.

Top module: `pair_word_alu`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `ya_out`, all five flag outputs, `flag_we` and `res_valid` are zero.
- R2: With `op_sel` = 2'b00 (add), `ya_out` equals (`ya_in` + `mem_in`) mod 2^16 one cycle after the strobe, with no carry-in.
- R3: With `op_sel` = 2'b01 (subtract), `ya_out` equals (`ya_in` - `mem_in`) mod 2^16 one cycle after the strobe, with no borrow-in.
- R4: C is the carry out of bit 15 on add. On subtract, C is 1 exactly when no borrow occurs, that is when `ya_in` >= `mem_in` as unsigned values.
- R5: On add and subtract, V is 1 exactly when the result overflows as a signed 16-bit two's-complement number, and 0 otherwise.
- R6: On add, H is 1 when bits 11:0 produce a carry into bit 12. On subtract, H is 1 when bits 11:0 need a borrow from bit 12, that is when `ya_in[11:0]` < `mem_in[11:0]`.
- R7: Whenever N or Z is written, N equals bit 15 of the new `ya_out` and Z is 1 exactly when all 16 bits of the new `ya_out` are zero.
- R8: With `op_sel` = 2'b10 (load), `ya_out` becomes `mem_in`, `flag_we` is 5'b10010, and the outputs `flag_v`, `flag_h` and `flag_c` keep their previous values.
- R9: `flag_we` bit order is {N, V, H, Z, C}, from bit 4 down to bit 0. After an add or subtract, `flag_we` is 5'b11111.
- R10: In a cycle without a strobe, the next cycle shows `res_valid` = 0 and `flag_we` = 0, and `ya_out` and all flags hold their values.
- R11: `op_sel` = 2'b11 is reserved. A strobe with it gives `res_valid` = 1 and `flag_we` = 0, and leaves `ya_out` and all flags unchanged.
- R12: `res_valid` equals `op_valid` delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 add, 01 subtract, 10 load, 11 reserved |
| ya_in | input | 16 | Current YA word (Y in bits 15:8, A in bits 7:0) |
| mem_in | input | 16 | Memory operand word |
| ya_out | output | 16 | Registered new YA word |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_h | output | 1 | Half-carry flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_we | output | 5 | Per-flag write enable {N,V,H,Z,C} |
| res_valid | output | 1 | Result and enables valid |

## Verification
Every result, flag, enable and valid bit is due on the rising edge that samples the strobe, so all of them can be observed one cycle later. Stimulus is applied on the falling edge. The bench samples 1 ns after the next rising edge and compares the outputs with a bench model that is stepped once per edge. This also covers hold behaviour after idle cycles, reserved strobes and loads. Back-to-back strobes, idle gaps and directed corner cases all use this same one-cycle alignment.

// File: rtl/pwalu_pkg.sv
package pwalu_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_LOAD = 2'b10,
      OP_RSVD = 2'b11
   } pwalu_op_e;

   localparam int FLAG_CNT = 5;
   localparam int FB_C = 0;
   localparam int FB_Z = 1;
   localparam int FB_H = 2;
   localparam int FB_V = 3;
   localparam int FB_N = 4;

   typedef struct packed {
      logic n;
      logic v;
      logic h;
      logic z;
      logic c;
   } pwalu_flags_t;
endpackage

// File: rtl/pwalu_addsub.sv
module pwalu_addsub #(
   parameter int W       = 16,
   parameter int HC_BIT  = 12,
   parameter int ADDER_STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         c_out,
   output logic         hc_out,
   output logic         ovf
);
   localparam int HI_W = W - HC_BIT;

   logic [W-1:0]      bx;
   logic [HC_BIT:0]   lo_sum;

   assign bx     = sub ? ~b : b;
   assign lo_sum = {1'b0, a[HC_BIT-1:0]} + {1'b0, bx[HC_BIT-1:0]}
                 + {{HC_BIT{1'b0}}, sub};
   assign hc_out = lo_sum[HC_BIT];

   generate
      if (ADDER_STYLE == 0) begin : g_wide
         logic [W:0] full_sum;
         assign full_sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
         assign res   = full_sum[W-1:0];
         assign c_out = full_sum[W];
      end else begin : g_split
         logic [HI_W:0] hi_sum;
         assign hi_sum = {1'b0, a[W-1:HC_BIT]} + {1'b0, bx[W-1:HC_BIT]}
                       + {{HI_W{1'b0}}, lo_sum[HC_BIT]};
         assign res   = {hi_sum[HI_W-1:0], lo_sum[HC_BIT-1:0]};
         assign c_out = hi_sum[HI_W];
      end
   endgenerate

   assign ovf = (a[W-1] == bx[W-1]) && (res[W-1] != a[W-1]);
endmodule

// File: rtl/pwalu_flagsel.sv
module pwalu_flagsel
   import pwalu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [1:0]          op,
   input  logic [W-1:0]        arith_res,
   input  logic                arith_c,
   input  logic                arith_hc,
   input  logic                arith_v,
   input  logic [W-1:0]        mem_word,
   output logic [W-1:0]        next_ya,
   output logic                ya_we,
   output pwalu_flags_t        next_flags,
   output logic [FLAG_CNT-1:0] next_we
);
   always_comb begin
      next_ya    = arith_res;
      ya_we      = 1'b0;
      next_flags = '0;
      next_we    = '0;
      case (pwalu_op_e'(op))
         OP_ADD, OP_SUB: begin
            next_ya      = arith_res;
            ya_we        = 1'b1;
            next_flags.c = arith_c;
            next_flags.v = arith_v;
            next_flags.h = (op == OP_SUB) ? ~arith_hc : arith_hc;
            next_we      = '1;
         end
         OP_LOAD: begin
            next_ya       = mem_word;
            ya_we         = 1'b1;
            next_we[FB_N] = 1'b1;
            next_we[FB_Z] = 1'b1;
         end
         default: begin
            ya_we   = 1'b0;
            next_we = '0;
         end
      endcase
      next_flags.n = next_ya[W-1];
      next_flags.z = (next_ya == '0);
   end
endmodule

// File: rtl/pair_word_alu.sv
module pair_word_alu
   import pwalu_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int HC_BIT      = 12,
   parameter int ADDER_STYLE = 0,
   localparam int W          = 2 * HALF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [1:0]          op_sel,
   input  logic [W-1:0]        ya_in,
   input  logic [W-1:0]        mem_in,
   output logic [W-1:0]        ya_out,
   output logic                flag_n,
   output logic                flag_v,
   output logic                flag_h,
   output logic                flag_z,
   output logic                flag_c,
   output logic [FLAG_CNT-1:0] flag_we,
   output logic                res_valid
);
   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("pair_word_alu: HALF_W must be at least 2");
      end
      if (HC_BIT < 1 || HC_BIT > W - 1) begin : g_bad_hc
         $error("pair_word_alu: HC_BIT must lie in 1..W-1");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("pair_word_alu: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic [W-1:0]        sum_w;
   logic                sum_c;
   logic                sum_hc;
   logic                sum_v;
   logic [W-1:0]        nxt_ya;
   logic                nxt_ya_we;
   pwalu_flags_t        nxt_flags;
   logic [FLAG_CNT-1:0] nxt_we;
   pwalu_flags_t        flags_q;

   pwalu_addsub #(
      .W           (W),
      .HC_BIT      (HC_BIT),
      .ADDER_STYLE (ADDER_STYLE)
   ) i_addsub (
      .a      (ya_in),
      .b      (mem_in),
      .sub    (op_sel == OP_SUB),
      .res    (sum_w),
      .c_out  (sum_c),
      .hc_out (sum_hc),
      .ovf    (sum_v)
   );

   pwalu_flagsel #(
      .W (W)
   ) i_flagsel (
      .op         (op_sel),
      .arith_res  (sum_w),
      .arith_c    (sum_c),
      .arith_hc   (sum_hc),
      .arith_v    (sum_v),
      .mem_word   (mem_in),
      .next_ya    (nxt_ya),
      .ya_we      (nxt_ya_we),
      .next_flags (nxt_flags),
      .next_we    (nxt_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ya_out    <= '0;
         flags_q   <= '0;
         flag_we   <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= op_valid;
         flag_we   <= op_valid ? nxt_we : '0;
         if (op_valid && nxt_ya_we) begin
            ya_out <= nxt_ya;
         end
         if (op_valid) begin
            if (nxt_we[FB_N]) flags_q.n <= nxt_flags.n;
            if (nxt_we[FB_V]) flags_q.v <= nxt_flags.v;
            if (nxt_we[FB_H]) flags_q.h <= nxt_flags.h;
            if (nxt_we[FB_Z]) flags_q.z <= nxt_flags.z;
            if (nxt_we[FB_C]) flags_q.c <= nxt_flags.c;
         end
      end
   end

   assign flag_n = flags_q.n;
   assign flag_v = flags_q.v;
   assign flag_h = flags_q.h;
   assign flag_z = flags_q.z;
   assign flag_c = flags_q.c;
endmodule

// File: rtl/pwalu_checker.sv
module pwalu_checker
   import pwalu_pkg::*;
#(
   parameter int W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic [1:0]          op_sel,
   input logic [W-1:0]        ya_in,
   input logic [W-1:0]        mem_in,
   input logic [W-1:0]        ya_out,
   input logic                flag_n,
   input logic                flag_v,
   input logic                flag_h,
   input logic                flag_z,
   input logic                flag_c,
   input logic [FLAG_CNT-1:0] flag_we,
   input logic                res_valid
);
   assert_valid_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
   assert_valid_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);
   assert_idle_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (flag_we == '0));
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(ya_out) && $stable(flag_c) && $stable(flag_v));
   assert_add_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_ADD) |=> ya_out == W'($past(ya_in) + $past(mem_in)));
   assert_sub_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_SUB) |=> ya_out == W'($past(ya_in) - $past(mem_in)));
   assert_load_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_LOAD) |=> (ya_out == $past(mem_in)) && (flag_we == 5'b10010)
                                          && $stable(flag_v) && $stable(flag_h) && $stable(flag_c));
   assert_arith_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == OP_ADD || op_sel == OP_SUB)) |=> flag_we == 5'b11111);
   assert_sub_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_SUB) |=> flag_c == ($past(ya_in) >= $past(mem_in)));
   assert_rsvd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_RSVD) |=> (flag_we == '0) && $stable(ya_out) && $stable(flag_z));
   assert_nz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we[FB_N] && flag_we[FB_Z]) |-> (flag_n == ya_out[W-1]) && (flag_z == (ya_out == '0)));
endmodule

bind pair_word_alu pwalu_checker #(.W(W)) i_pwalu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_sel    (op_sel),
   .ya_in     (ya_in),
   .mem_in    (mem_in),
   .ya_out    (ya_out),
   .flag_n    (flag_n),
   .flag_v    (flag_v),
   .flag_h    (flag_h),
   .flag_z    (flag_z),
   .flag_c    (flag_c),
   .flag_we   (flag_we),
   .res_valid (res_valid)
);

// File: tb/test_pair_word_alu.sv
module test_pair_word_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [15:0] ya_in = '0;
   logic [15:0] mem_in = '0;
   logic [15:0] ya_out;
   logic        flag_n, flag_v, flag_h, flag_z, flag_c;
   logic [4:0]  flag_we;
   logic        res_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [15:0] m_ya = '0;
   logic        m_n = 0, m_v = 0, m_h = 0, m_z = 0, m_c = 0;
   logic [4:0]  m_we = '0;
   logic        m_rv = 0;

   always #5 clk = ~clk;

   pair_word_alu i_pair_word_alu (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_sel    (op_sel),
      .ya_in     (ya_in),
      .mem_in    (mem_in),
      .ya_out    (ya_out),
      .flag_n    (flag_n),
      .flag_v    (flag_v),
      .flag_h    (flag_h),
      .flag_z    (flag_z),
      .flag_c    (flag_c),
      .flag_we   (flag_we),
      .res_valid (res_valid)
   );

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Bench model, one step per sampling edge
   task automatic model_step(logic v, logic [1:0] op, logic [15:0] a, logic [15:0] b);
      logic [16:0] s;
      logic [12:0] hs;
      m_rv = v;
      m_we = '0;
      if (v) begin
         case (op)
            2'b00: begin
               s  = {1'b0, a} + {1'b0, b};
               hs = {1'b0, a[11:0]} + {1'b0, b[11:0]};
               m_ya = s[15:0];
               m_c  = s[16];
               m_h  = hs[12];
               m_v  = (a[15] == b[15]) && (m_ya[15] != a[15]);
               m_n  = m_ya[15];
               m_z  = (m_ya == 16'h0);
               m_we = 5'b11111;
            end
            2'b01: begin
               m_ya = a - b;
               m_c  = (a >= b);
               m_h  = (a[11:0] < b[11:0]);
               m_v  = (a[15] != b[15]) && (m_ya[15] != a[15]);
               m_n  = m_ya[15];
               m_z  = (m_ya == 16'h0);
               m_we = 5'b11111;
            end
            2'b10: begin
               m_ya = b;
               m_n  = b[15];
               m_z  = (b == 16'h0);
               m_we = 5'b10010;
            end
            default: m_we = '0;
         endcase
      end
   endtask

   function automatic string tags_for(logic v, logic [1:0] op);
      if (!v) return "R10 R12";
      case (op)
         2'b00:   return "R2 R4 R5 R6 R7 R9 R12";
         2'b01:   return "R3 R4 R5 R6 R7 R9 R12";
         2'b10:   return "R8 R7 R12";
         default: return "R11 R12";
      endcase
   endfunction

   task automatic check_all(string tag);
      chk({tag, " ya_out"}, ya_out, m_ya);
      chk({tag, " flags NVHZC"}, {11'd0, flag_n, flag_v, flag_h, flag_z, flag_c},
          {11'd0, m_n, m_v, m_h, m_z, m_c});
      chk({tag, " flag_we"}, {11'd0, flag_we}, {11'd0, m_we});
      chk({tag, " res_valid"}, {15'd0, res_valid}, {15'd0, m_rv});
   endtask

   task automatic issue(logic v, logic [1:0] op, logic [15:0] a, logic [15:0] b);
      @(negedge clk);
      op_valid = v;
      op_sel   = op;
      ya_in    = a;
      mem_in   = b;
      @(posedge clk);
      model_step(v, op, a, b);
      #1;
      check_all(tags_for(v, op));
   endtask

   initial begin
      void'($urandom(32'h5A17C3));
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_all("R1 after release");

      // directed corners
      issue(1, 2'b00, 16'h7FFF, 16'h0001); // R5 signed overflow on add, R6 H
      issue(1, 2'b00, 16'hFFFF, 16'h0001); // R4 carry, R7 zero
      issue(1, 2'b00, 16'h0FFF, 16'h0001); // R6 half carry only
      issue(1, 2'b00, 16'h1234, 16'h0000); // no flags
      issue(1, 2'b01, 16'h8000, 16'h0001); // R5 overflow on subtract
      issue(1, 2'b01, 16'h0000, 16'h0001); // R4 borrow gives C=0, R6 H
      issue(1, 2'b01, 16'h4321, 16'h4321); // R7 zero, R4 C=1
      issue(1, 2'b01, 16'h1000, 16'h0001); // R6 half borrow, C=1
      issue(1, 2'b00, 16'h8000, 16'h8000); // C, V, Z together
      issue(1, 2'b10, 16'hAAAA, 16'h8000); // R8 load keeps C,V
      issue(1, 2'b10, 16'h5555, 16'h0000); // R8 load of zero
      issue(0, 2'b00, 16'h1111, 16'h2222); // R10 idle
      issue(1, 2'b11, 16'h3333, 16'h4444); // R11 reserved
      issue(0, 2'b01, 16'hFFFF, 16'hFFFF); // R10 idle again
      issue(1, 2'b01, 16'h7FFF, 16'hFFFF); // R5 overflow positive side

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [1:0]  op;
         logic [15:0] a, b;
         logic        v;
         v  = ($urandom_range(0, 7) != 0);
         op = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
         a  = 16'($urandom);
         b  = ($urandom_range(0, 9) == 0) ? a : 16'($urandom);
         issue(v, op, a, b);
      end

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule